// File: doc/BRIEF.md
# Full-Cycle Five-Bit Pattern Generator with Zero State

This block produces a stream of 5-bit test patterns from a shift register with linear feedback. A plain maximal-length register of this kind never reaches the all-zero value, so its cycle has 31 states. Here a detector watches the four stages that survive each shift. When they are all zero, its output is folded into the feedback. The all-zero value is then spliced into the cycle right after `00001`, and the period becomes a full 32 states. Every 5-bit value appears exactly once per period.

Two feedback structures are offered, chosen by a mode input. In the standard form the XOR of the tapped stages drives a single new bit into the top stage. In the modular form the bit leaving the bottom stage is XORed into the tapped positions as the register shifts. Both forms cover all 32 values. A synchronous reset loads a fixed nonzero seed, and an enable input gates every update. A flag output marks the cycle in which the register holds all zeros, so a consumer can count complete periods.

The generator is meant to drive circuit inputs during self-test. Because the sequence is exhaustive, it applies every input combination of a 5-input cone, including the all-zero pattern.

Top module: `debruijn_lfsr`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes `00001` at that edge, whatever the values of `en` and `mode`.
- R2: When `rst` is low and `en` is low at a rising edge, `state` keeps its value, whatever the value of `mode`.
- R3: With `mode` = 0 (standard form) and `en` high, the next state is {f, s[4:1]}. Here f = s[0] XOR s[3] XOR z, and z is 1 exactly when s[4:1] are all zero. The bits are written s[4] down to s[0], and s[4] is the most significant bit of `state`.
- R4: With `mode` = 1 (modular form) and `en` high, let g = s[0] XOR z. The next state is (s >> 1) XOR (g ? `10010` : `00000`).
- R5: In both forms, `00001` is followed by `00000`. The state `00000` is followed by `10000` in the standard form and by `10010` in the modular form.
- R6: In either form, 32 consecutive enabled cycles with a constant `mode` visit 32 distinct states and return to the starting state, from any starting state.
- R7: `zero_flag` is high exactly when `state` equals `00000`, which happens once in every 32 enabled cycles under a constant `mode`.
- R8: A change of `mode` takes effect at the next enabled edge. The stored state is kept and simply advanced by the newly selected rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, loads the seed `00001` |
| en | input | 1 | Advance the sequence when high, hold when low |
| mode | input | 1 | Feedback structure: 0 standard, 1 modular |
| state | output | 5 | Current pattern |
| zero_flag | output | 1 | High while the pattern is all zeros |

## Verification
Some behaviours are checked by assertions on every cycle:
- the seed load after reset;
- holding while disabled;
- the flag agreeing with the pattern;
- both splice transitions around the zero state;
- the gap of exactly 32 enabled cycles between visits to zero while the mode is unchanged.

Other behaviours can only be shown by the bench scenarios:
- the full next-state rule of each structure against an independent model;
- the distinctness of all 32 states in a period;
- the continuation of the walk from a mid-sequence state after a mode change;
- the priority of reset over enable.

// File: rtl/debruijn_lfsr_pkg.sv
package debruijn_lfsr_pkg;

    localparam int unsigned GEN_W = 5;

    // Standard form: parity of these stages forms the incoming top bit.
    localparam logic [GEN_W-1:0] STD_TAPS = 5'b01001;

    // Modular form: positions toggled by the bit leaving the bottom stage.
    localparam logic [GEN_W-1:0] MOD_MASK = 5'b10010;

    localparam logic [GEN_W-1:0] SEED = 5'b00001;

    typedef enum logic {
        FORM_STANDARD = 1'b0,
        FORM_MODULAR  = 1'b1
    } form_e;

    typedef struct packed {
        logic upper_clear;  // all stages except the bottom one are zero
        logic all_clear;    // every stage is zero
    } zero_info_t;

    function automatic logic parity_of(input logic [GEN_W-1:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/debruijn_zero_detect.sv
module debruijn_zero_detect
    import debruijn_lfsr_pkg::*;
#(
    parameter int unsigned W = GEN_W
) (
    input  logic [W-1:0] cur,
    output zero_info_t   info
);

    logic upper_nor;

    assign upper_nor        = ~|cur[W-1:1];
    assign info.upper_clear = upper_nor;
    assign info.all_clear   = upper_nor & ~cur[0];

endmodule

// File: rtl/debruijn_std_next.sv
module debruijn_std_next
    import debruijn_lfsr_pkg::*;
#(
    parameter int unsigned   W         = GEN_W,
    parameter logic [W-1:0]  TAPS      = STD_TAPS,
    parameter bit            MINIMIZED = 1'b1
) (
    input  logic [W-1:0] cur,
    input  logic         upper_clear,
    output logic [W-1:0] nxt
);

    logic lin_fb;
    logic fb;

    assign lin_fb = ^(cur & TAPS);

    generate
        if (MINIMIZED) begin : g_min
            // When the upper stages are clear only the bottom tap is live,
            // so the sum collapses to the inverted bottom stage.
            assign fb = upper_clear ? ~cur[0] : lin_fb;
        end else begin : g_xor
            assign fb = lin_fb ^ upper_clear;
        end
    endgenerate

    assign nxt = {fb, cur[W-1:1]};

endmodule

// File: rtl/debruijn_mod_next.sv
module debruijn_mod_next
    import debruijn_lfsr_pkg::*;
#(
    parameter int unsigned  W    = GEN_W,
    parameter logic [W-1:0] MASK = MOD_MASK
) (
    input  logic [W-1:0] cur,
    input  logic         upper_clear,
    output logic [W-1:0] nxt
);

    logic out_bit;

    assign out_bit = cur[0] ^ upper_clear;
    assign nxt     = (cur >> 1) ^ ({W{out_bit}} & MASK);

endmodule

// File: rtl/debruijn_lfsr.sv
module debruijn_lfsr
    import debruijn_lfsr_pkg::*;
#(
    parameter int unsigned  W         = GEN_W,
    parameter logic [W-1:0] STD_T     = STD_TAPS,
    parameter logic [W-1:0] MOD_M     = MOD_MASK,
    parameter logic [W-1:0] RST_SEED  = SEED,
    parameter bit           MINIMIZED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         mode,
    output logic [W-1:0] state,
    output logic         zero_flag
);

    form_e       form;
    zero_info_t  zinfo;
    logic [W-1:0] std_nxt;
    logic [W-1:0] mod_nxt;
    logic [W-1:0] sel_nxt;
    logic [W-1:0] state_q;

    assign form = form_e'(mode);

    debruijn_zero_detect #(.W(W)) u_zdet (
        .cur  (state_q),
        .info (zinfo)
    );

    debruijn_std_next #(.W(W), .TAPS(STD_T), .MINIMIZED(MINIMIZED)) u_std (
        .cur         (state_q),
        .upper_clear (zinfo.upper_clear),
        .nxt         (std_nxt)
    );

    debruijn_mod_next #(.W(W), .MASK(MOD_M)) u_mod (
        .cur         (state_q),
        .upper_clear (zinfo.upper_clear),
        .nxt         (mod_nxt)
    );

    always_comb begin
        unique case (form)
            FORM_STANDARD: sel_nxt = std_nxt;
            FORM_MODULAR:  sel_nxt = mod_nxt;
            default:       sel_nxt = std_nxt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_SEED;
        end else if (en) begin
            state_q <= sel_nxt;
        end
    end

    assign state     = state_q;
    assign zero_flag = zinfo.all_clear;

endmodule

// File: rtl/debruijn_lfsr_checker.sv
module debruijn_lfsr_checker
    import debruijn_lfsr_pkg::*;
#(
    parameter int unsigned  W     = GEN_W,
    parameter logic [W-1:0] MOD_M = MOD_MASK
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         mode,
    input logic [W-1:0] state,
    input logic         zero_flag
);

    localparam int unsigned PERIOD = 1 << W;
    localparam int unsigned CW     = W + 1;
    localparam logic [W-1:0] STD_AFTER_ZERO = {1'b1, {(W-1){1'b0}}};

    logic [CW-1:0] gap;
    logic          seen;
    logic          mixed;
    logic          mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            seen   <= 1'b0;
            mixed  <= 1'b0;
            mode_q <= mode;
        end else if (en) begin
            mode_q <= mode;
            if (state == '0) begin
                gap   <= '0;
                seen  <= 1'b1;
                mixed <= 1'b0;
            end else begin
                gap <= gap + 1'b1;
                if (mode != mode_q) mixed <= 1'b1;
            end
        end
    end

    assert_reset_seed_R1: assert property (@(posedge clk)
        rst |=> state == {{(W-1){1'b0}}, 1'b1});

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));

    assert_enter_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (en && state == {{(W-1){1'b0}}, 1'b1}) |=> state == '0);

    assert_leave_zero_std_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !mode && state == '0) |=> state == STD_AFTER_ZERO);

    assert_leave_zero_mod_R5: assert property (@(posedge clk) disable iff (rst)
        (en && mode && state == '0) |=> state == MOD_M);

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        zero_flag == (state == '0));

    assert_period_R6: assert property (@(posedge clk) disable iff (rst)
        (en && state == '0 && seen && !mixed) |-> gap == CW'(PERIOD - 1));

endmodule

bind debruijn_lfsr debruijn_lfsr_checker #(.W(W), .MOD_M(MOD_M)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode      (mode),
    .state     (state),
    .zero_flag (zero_flag)
);

// File: tb/tb_debruijn_lfsr.sv
module tb_debruijn_lfsr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       mode = 1'b0;
    logic [4:0] state;
    logic       zero_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    debruijn_lfsr dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode),
        .state     (state),
        .zero_flag (zero_flag)
    );

    // {rst, mode, en, expected state after the edge}
    localparam logic [7:0] VEC [0:19] = '{
        8'b1_0_0_00001,
        8'b0_0_1_00000, 8'b0_0_1_10000, 8'b0_0_1_01000, 8'b0_0_1_10100,
        8'b0_0_1_01010, 8'b0_0_1_10101, 8'b0_0_1_11010, 8'b0_0_1_11101,
        8'b0_0_0_11101,
        8'b1_1_1_00001,
        8'b0_1_1_00000, 8'b0_1_1_10010, 8'b0_1_1_01001, 8'b0_1_1_10110,
        8'b0_1_1_01011, 8'b0_1_1_10111, 8'b0_1_1_11001, 8'b0_1_1_11110,
        8'b0_1_0_11110
    };

    function automatic logic [4:0] model(input logic [4:0] s, input logic m);
        logic z;
        logic b;
        z = (s[4:1] == 4'd0);
        if (!m) begin
            b = s[0] ^ s[3] ^ z;
            return {b, s[4:1]};
        end
        b = s[0] ^ z;
        return {1'b0, s[4:1]} ^ (b ? 5'b10010 : 5'b00000);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic m, input logic e);
        @(negedge clk);
        rst  = r;
        mode = m;
        en   = e;
        @(posedge clk);
        #2;
    endtask

    // Walk one full period under a constant mode, starting from the current state.
    task automatic full_period(input logic m, input string req);
        logic [4:0] start;
        logic [4:0] exp_s;
        bit [31:0]  visited;
        int         zeros;
        start   = state;
        exp_s   = state;
        visited = '0;
        zeros   = 0;
        for (int i = 0; i < 32; i++) begin
            check(!visited[state], req, int'(state), -1);
            visited[state] = 1'b1;
            if (zero_flag) zeros++;
            check(zero_flag == (state == 5'd0), "R7", int'(zero_flag), int'(state == 5'd0));
            exp_s = model(exp_s, m);
            drive(1'b0, m, 1'b1);
            check(state == exp_s, req, int'(state), int'(exp_s));
        end
        check(state == start, "R6", int'(state), int'(start));
        check(visited == 32'hFFFF_FFFF, "R6", 0, 1);
        check(zeros == 1, "R7", zeros, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] prev;
        logic [4:0] exp_s;

        // R1: reset state
        drive(1'b1, 1'b0, 1'b0);
        check(state == 5'b00001, "R1", int'(state), 1);
        check(zero_flag == 1'b0, "R7", int'(zero_flag), 0);
        // R1: reset wins over enable
        drive(1'b1, 1'b0, 1'b1);
        drive(1'b1, 1'b1, 1'b1);
        check(state == 5'b00001, "R1", int'(state), 1);

        // Table walk: R1 R2 R3 R4 R5
        foreach (VEC[i]) begin
            drive(VEC[i][7], VEC[i][6], VEC[i][5]);
            check(state == VEC[i][4:0], "R3/R4 table", int'(state), int'(VEC[i][4:0]));
        end

        // R5: zero entry flag
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        check(state == 5'b00000, "R5", int'(state), 0);
        check(zero_flag == 1'b1, "R7", int'(zero_flag), 1);

        // R3 R6 R7: full standard period
        drive(1'b1, 1'b0, 1'b0);
        full_period(1'b0, "R3");

        // R4 R6 R7: full modular period
        drive(1'b1, 1'b1, 1'b0);
        full_period(1'b1, "R4");

        // R2: enable low holds while mode toggles
        drive(1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b1);
        prev = state;
        for (int i = 0; i < 6; i++) begin
            drive(1'b0, i[0], 1'b0);
            check(state == prev, "R2", int'(state), int'(prev));
        end

        // R8: switch mode mid-sequence, state is kept
        drive(1'b1, 1'b0, 1'b0);
        exp_s = 5'b00001;
        for (int i = 0; i < 5; i++) begin
            exp_s = model(exp_s, 1'b0);
            drive(1'b0, 1'b0, 1'b1);
        end
        check(state == exp_s, "R3", int'(state), int'(exp_s));
        prev  = state;
        exp_s = model(prev, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        check(state == exp_s, "R8", int'(state), int'(exp_s));
        // R6: period from a non-seed start in modular form
        full_period(1'b1, "R6");
        // R8 back to standard from mid-sequence, then full period
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1);
        prev  = state;
        exp_s = model(prev, 1'b0);
        drive(1'b0, 1'b0, 1'b1);
        check(state == exp_s, "R8", int'(state), int'(exp_s));
        full_period(1'b0, "R6");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule